// File: doc/BRIEF.md
# Serial flash bulk-erase controller

This block is the slave-side command logic of a serial flash device, cut down to the chip-wide erase path. A host selects the device with an active-low select, clocks 8-bit instruction codes in MSB first, and reads a status byte back on the serial output. The block keeps a write-enable latch and two block-protect bits. It accepts a chip-wide erase only when the command framing, the latch and the protection all allow it. It then runs a self-timed erase cycle of a fixed number of system clocks, and ends by pulsing an erase-all request to the memory model, which then returns FFh for every byte.

All serial inputs are sampled by the system clock through two-flop synchronizers, and edges of the serial clock and of the select are found in the system-clock domain. The serial clock must therefore run well below the system clock. The host polls the write-in-progress flag with repeated status reads while the erase runs. A write-status command sets the protect bits.

Top module: `spi_bulk_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, sdo_o is 0 and erase_all_o is 0.
- R2: Instruction 06h, ended by the select going high after exactly 8 bits, sets the write-enable latch (status bit 1).
- R3: After the 8 bits of instruction 05h, the status byte {0000, BP1, BP0, latch, in-progress} is driven MSB first, with each bit changing after a falling serial-clock edge. The byte repeats with live values for as long as the select stays low, and sdo_o returns to 0 once the select is high.
- R4: Instruction C7h starts an erase only when the select goes high after exactly 8 bits. A frame of 7 or 9 bits does nothing.
- R5: Instruction C7h does nothing while the write-enable latch is 0.
- R6: Instruction C7h does nothing unless BP1 (status bit 3) and BP0 (status bit 2) are both 0. A rejected erase leaves the latch unchanged.
- R7: An accepted erase holds write-in-progress (status bit 0) at 1 for exactly T_BE system cycles. At the end it clears the latch and gives a one-cycle pulse on erase_all_o.
- R8: While write-in-progress is 1, every instruction other than 05h is ignored.
- R9: Instruction 01h followed by one data byte, framed to exactly 16 bits and given while the latch is 1, loads BP1 and BP0 from data bits 3 and 2 and clears the latch. Any other frame length does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in, sampled on rising sck_i |
| sdo_o | output | 1 | Serial data out, status byte |
| erase_all_o | output | 1 | One-cycle request to set the whole array to FFh |

## Verification
A latch or protect bit held in the wrong state shows up in the next status read as a wrong bit 1, 2 or 3. It also shows up at the end of the next erase attempt as a missing or extra pulse on erase_all_o. A wrong bit count or opcode capture shows up when the select rises, as a state change that should not have happened; the next status read exposes it. A wrong erase timer shows up as a pulse count that differs after the wait, or as a polled busy flag that is wrong mid-cycle. Its exact length is held to T_BE cycles on every erase.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'hC7;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  typedef struct packed {
    logic [3:0] rsvd;
    logic [1:0] bp;   // [1] = BP1 at bit 3, [0] = BP0 at bit 2
    logic       wel;
    logic       wip;
  } status_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           W    = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] m1_q, m2_q, m3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q <= INIT;
      m2_q <= INIT;
      m3_q <= INIT;
    end else begin
      m1_q <= d_i;
      m2_q <= m1_q;
      m3_q <= m2_q;
    end
  end

  assign q_o    = m2_q;
  assign rise_o = m2_q & ~m3_q;
  assign fall_o = ~m2_q & m3_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_erase_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SH_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             start_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             sdi_i,
  input  logic [7:0]       status_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [SH_W-1:0]  shreg_o,
  output logic             sdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_OPEND = CNT_W'(7);

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  logic             rd_q;
  logic [2:0]       ocnt_q;
  logic [7:0]       osh_q;
  logic             sdo_q;
  logic [7:0]       op_next;

  assign op_next = {sh_q[6:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      ocnt_q <= '0;
      osh_q  <= '0;
      sdo_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      ocnt_q <= '0;
      osh_q  <= '0;
      sdo_q  <= 1'b0;
    end else if (!sel_i) begin
      rd_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        sh_q <= {sh_q[SH_W-2:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_OPEND && op_next == OP_RDSR) rd_q <= 1'b1;
      end
      if (sck_fall_i && rd_q) begin
        // reload live status at each byte boundary
        if (ocnt_q == 3'd0) begin
          sdo_q <= status_i[7];
          osh_q <= {status_i[6:0], 1'b0};
        end else begin
          sdo_q <= osh_q[7];
          osh_q <= {osh_q[6:0], 1'b0};
        end
        ocnt_q <= ocnt_q + 3'd1;
      end
    end
  end

  assign bit_cnt_o = cnt_q;
  assign shreg_o   = sh_q;
  assign sdo_o     = sdo_q;
endmodule

// File: rtl/spi_erase_timer.sv
module spi_erase_timer #(
  parameter int T_BE = 4096,
  parameter int TW   = (T_BE > 1) ? $clog2(T_BE) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  localparam logic [TW-1:0] LOAD = TW'(T_BE - 1);

  logic [TW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign last_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= LOAD;
        end
      end else if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_bulk_erase_ctrl.sv
module spi_bulk_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int T_BE = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic erase_all_o
);
  localparam int CNT_W = 5;
  localparam int SH_W  = 16;
  localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_WRSR = CNT_W'(16);

  logic [2:0] s_q, s_rise, s_fall;
  logic       cs_q, cs_rise, cs_fall;

  spi_in_sync #(.W(3), .INIT(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdi_i}),
    .q_o    (s_q),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign cs_q    = s_q[2];
  assign cs_rise = s_rise[2];
  assign cs_fall = s_fall[2];

  logic             wel, wip, erase_last;
  logic [1:0]       bp;
  status_t          status;
  logic [CNT_W-1:0] bit_cnt;
  logic [SH_W-1:0]  shreg;

  assign status = '{rsvd: 4'h0, bp: bp, wel: wel, wip: wip};

  spi_cmd_shifter #(.CNT_W(CNT_W), .SH_W(SH_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (!cs_q),
    .start_i    (cs_fall),
    .sck_rise_i (s_rise[1]),
    .sck_fall_i (s_fall[1]),
    .sdi_i      (s_q[0]),
    .status_i   (status),
    .bit_cnt_o  (bit_cnt),
    .shreg_o    (shreg),
    .sdo_o      (sdo_o)
  );

  logic commit, wren_go, erase_go, wrsr_go;

  always_comb begin
    commit   = cs_rise && !wip;
    wren_go  = commit && bit_cnt == LEN_CMD && shreg[7:0] == OP_WREN;
    erase_go = commit && bit_cnt == LEN_CMD && shreg[7:0] == OP_ERASE
               && wel && bp == 2'b00;
    wrsr_go  = commit && bit_cnt == LEN_WRSR && shreg[15:8] == OP_WRSR && wel;
  end

  spi_erase_timer #(.T_BE(T_BE)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (erase_go),
    .busy_o  (wip),
    .last_o  (erase_last),
    .done_o  (erase_all_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel <= 1'b0;
      bp  <= 2'b00;
    end else begin
      if (erase_last || wrsr_go) wel <= 1'b0;
      else if (wren_go)          wel <= 1'b1;
      if (wrsr_go) bp <= shreg[3:2];
    end
  end
endmodule

// File: rtl/spi_bulk_erase_chk.sv
module spi_bulk_erase_chk #(
  parameter int T_BE = 4096
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       cs_rise_i,
  input logic       wip_i,
  input logic       wel_i,
  input logic [1:0] bp_i,
  input logic       erase_all_i,
  input logic       sdo_i
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    busy_cnt <= 0;
    else if (wip_i) busy_cnt <= busy_cnt + 1;
    else            busy_cnt <= 0;
  end

  assert_sdo_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && $past(cs_i)) |-> !sdo_i);
  assert_start_on_deselect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(cs_rise_i));
  assert_start_needs_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(wel_i));
  assert_start_unprotected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(bp_i) == 2'b00);
  assert_erase_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |-> busy_cnt == T_BE);
  assert_erase_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |=> !erase_all_i);
  assert_erase_end_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |-> (!wel_i && !wip_i));
  assert_wip_fall_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> erase_all_i);
  assert_busy_locks_bp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |=> $stable(bp_i));
endmodule

bind spi_bulk_erase_ctrl spi_bulk_erase_chk #(.T_BE(T_BE)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_q),
  .cs_rise_i   (cs_rise),
  .wip_i       (wip),
  .wel_i       (wel),
  .bp_i        (bp),
  .erase_all_i (erase_all_o),
  .sdo_i       (sdo_o)
);

// File: tb/test_spi_bulk_erase_ctrl.sv
module test_spi_bulk_erase_ctrl;
  localparam int T_BE = 1500;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, erase_all;
  int   n_chk = 0, n_fail = 0, pulses = 0;
  bit   ended = 1'b0;

  always #2 clk = ~clk;

  spi_bulk_erase_ctrl #(.T_BE(T_BE)) i_spi_bulk_erase_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .erase_all_o(erase_all)
  );

  always @(posedge clk) if (erase_all) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sck = 1'b0; sdi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1; rx = {rx[30:0], sdo};
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic [1:0] bp, input logic wel, input logic wip);
    return {4'h0, bp, wel, wip};
  endfunction

  task automatic rdsr(output logic [7:0] s);
    logic [31:0] rx;
    frame(32'h0500, 16, rx);
    s = rx[7:0];
  endtask

  logic [31:0] rx;
  logic [7:0]  st;
  logic [1:0]  e_bp = 2'b00;
  logic        e_wel = 1'b0;
  int          e_pulses = 0;

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 sdo", {31'd0, sdo}, 0);
    chk("R1 erase_all", {31'd0, erase_all}, 0);
    rdsr(st); chk("R1 status", st, 8'h00);

    frame(32'hC7, 8, rx); rdsr(st);
    chk("R5 erase w/o latch", st, 8'h00);
    frame(32'h06, 8, rx); rdsr(st);
    chk("R2 latch set", st, 8'h02);
    frame(32'h010C, 16, rx); rdsr(st);
    chk("R9 protect set", st, 8'h0C);
    frame(32'h06, 8, rx); frame(32'hC7, 8, rx); rdsr(st);
    chk("R6 erase protected", st, 8'h0E);
    frame(32'h0100, 16, rx); rdsr(st);
    chk("R9 protect clear", st, 8'h00);
    frame(32'h06, 8, rx);
    frame(32'h63, 7, rx); rdsr(st);
    chk("R4 short frame", st, 8'h02);
    frame(32'h18E, 9, rx); rdsr(st);
    chk("R4 long frame", st, 8'h02);
    frame(32'h0600, 15, rx); rdsr(st);
    chk("R9 short write-status", st, 8'h02);
    repeat (T_BE) @(negedge clk);
    chk("R4 no pulse", pulses, 0);

    frame(32'hC7, 8, rx); rdsr(st);
    chk("R7 busy", st, 8'h03);
    frame(32'h050000, 24, rx);
    chk("R3 repeat byte0", rx[15:8], 8'h03);
    chk("R3 repeat byte1", rx[7:0], 8'h03);
    frame(32'h010C, 16, rx); rdsr(st);
    chk("R8 write-status ignored", st, 8'h03);
    repeat (T_BE + 40) @(negedge clk);
    rdsr(st);
    chk("R7 done status", st, 8'h00);
    chk("R7 one pulse", pulses, 1);
    chk("R3 sdo idle", {31'd0, sdo}, 0);
    e_pulses = 1;

    for (int it = 0; it < 40; it++) begin
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0, 1: begin
          frame(32'h06, 8, rx); e_wel = 1'b1;
        end
        2: begin
          frame(32'hC7, 8, rx);
          if (e_wel && e_bp == 2'b00) begin
            e_wel = 1'b0; e_pulses++;
            repeat (T_BE + 40) @(negedge clk);
          end
        end
        3: begin
          if ($urandom_range(0, 1) == 1) frame(32'h63, 7, rx);
          else                           frame(32'h18F, 9, rx);
        end
        4: begin
          logic [7:0] d;
          int nb;
          d  = ($urandom_range(0, 1) == 1) ? 8'h00 : 8'($urandom_range(0, 255));
          nb = ($urandom_range(0, 3) == 0) ? 15 : 16;
          if (nb == 16) frame({16'h0, 8'h01, d}, 16, rx);
          else          frame({17'h0, 7'h00, d}, 15, rx);
          if (nb == 16 && e_wel) begin
            e_bp = d[3:2]; e_wel = 1'b0;
          end
        end
        default: begin
          logic [7:0] op;
          do op = 8'($urandom_range(0, 255));
          while (op == 8'h06 || op == 8'hC7);
          frame({24'h0, op}, 8, rx);
        end
      endcase
      rdsr(st);
      chk("R2 R5 R6 R9 random status", st, stat(e_bp, e_wel, 1'b0));
      chk("R7 random pulse count", pulses, e_pulses);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule